// File: doc/BRIEF.md
# Two-Wire Configuration Memory Slave

This block is a slave on a two-wire serial bus, clock line plus open-drain data line. It gives a bus master byte-wide read and write access to a small on-chip configuration store. A typical use is the presence-detect data held on a memory module. The block samples both bus lines with its own system clock through a two-flop synchronizer and finds the bus clock edges and the start and stop conditions from those samples. It never drives the data line high. It only asserts an output enable that the pad turns into a low level.

A transfer opens with a start condition and an address byte: a 7-bit device address sent MSB first, followed by a direction bit. After a write address, the first byte sets the internal word pointer and every later byte is stored at the pointer. After a read address, the slave streams bytes from the pointer for as long as the master acknowledges each one. The pointer advances after every data byte in either direction and wraps from the last location back to zero. A repeated start may follow a word-address byte, which gives a random-address read. A stop condition always returns the slave to standby.

Top module: `cfg_eeprom_slave`

## Requirements
- R1: After reset the slave does not drive the data line (`sda_oe` = 0) and is in standby.
- R2: In standby the slave ignores all clocked bus traffic: it sends no acknowledge and keeps `sda_oe` low until a start condition (data falling while the clock is high) is seen.
- R3: After a start, an address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: `sda_oe` is held high for the whole ninth clock. Any other address gets no acknowledge, and the slave stays silent until the next start.
- R4: In a write transfer the slave acknowledges every byte after the address byte. The first of those bytes loads the word pointer from its low `$clog2(DEPTH)` bits. Each later byte is written to the location the pointer names.
- R5: In a read transfer the slave sends the byte at the word pointer MSB first. A data bit of 0 is sent as `sda_oe` = 1, and a bit of 1 as `sda_oe` = 0. The data line is released during the ninth clock.
- R6: When the master drives the data line low on the ninth clock after a read byte, the slave sends the byte at the next location.
- R7: When the master leaves the data line high on the ninth clock after a read byte, the slave stops sending and keeps `sda_oe` low until a stop or a new start.
- R8: The word pointer advances by one after every data byte read or written and wraps from `DEPTH-1` to 0.
- R9: `sda_oe` rises only while the synchronized bus clock is low.
- R10: A stop condition (data rising while the clock is high) returns the slave to standby from any state, and releases the data line.
- R11: A start condition seen in the middle of a transfer restarts the address phase. The word pointer keeps its value, so a following read continues from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Data line pull-down enable (1 drives the line low) |

## Verification
Two functions can act in the same system-clock cycle. One is a start or stop condition; the other is the bit engine handling a clock edge in the middle of a byte or an acknowledge. The bench provokes this in three ways. It issues a repeated start right after a word-address byte, while the controller is still in its receive flow. It clocks an extra byte after a read that ended without an acknowledge. It sends bytes without a start just after a stop. In each case the data line is judged at the ports: the acknowledge bit sampled on the ninth clock, and the data sent back on a later read. The read must return the bytes written at the retained pointer. The bytes sent without a start, or after the missing acknowledge, must produce no pull-down.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_TXLOAD,
    ST_WAIT
  } tw_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WORD,
    RX_DATA
  } rx_kind_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (sel) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < DEPTH)); // R8

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         DEPTH    = 16,
  localparam int        AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr
);

  tw_state_e     state_q, state_d;
  rx_kind_e      kind_q, kind_d;
  logic [2:0]    bitcnt_q, bitcnt_d;
  logic [6:0]    shreg_q, shreg_d;
  logic [6:0]    txsh_q, txsh_d;
  logic          done_q, done_d;
  logic          ackok_q, ackok_d;
  logic          rw_q, rw_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          oe_q, oe_d;
  logic          scl_q, sda_q;

  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr_inc;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rx_byte   = {shreg_q, sda_s};
  assign ptr_inc   = (ptr_q == AW'(DEPTH-1)) ? '0 : ptr_q + AW'(1);

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    done_d   = done_q;
    ackok_d  = ackok_q;
    rw_d     = rw_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d  = ST_RX;
      kind_d   = RX_DEV;
      bitcnt_d = '0;
      done_d   = 1'b0;
      oe_d     = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: oe_d = 1'b0;
        ST_RX: begin
          if (scl_rise && !done_q) begin
            shreg_d  = rx_byte[6:0];
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              done_d = 1'b1;
              unique case (kind_q)
                RX_DEV: begin
                  ackok_d = (rx_byte[7:1] == DEV_ADDR);
                  rw_d    = rx_byte[0];
                end
                RX_WORD: begin
                  ptr_d   = rx_byte[AW-1:0];
                  ackok_d = 1'b1;
                end
                default: begin
                  wr_en   = 1'b1;
                  ptr_d   = ptr_inc;
                  ackok_d = 1'b1;
                end
              endcase
            end
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            if (ackok_q) begin
              oe_d    = 1'b1;
              state_d = ST_ACK;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (kind_q == RX_DEV && rw_q) begin
              state_d = ST_TX;
              txsh_d  = rd_data[6:0];
              oe_d    = ~rd_data[7];
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
              kind_d  = (kind_q == RX_DEV) ? RX_WORD : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 3'd7) begin
              oe_d    = 1'b0;
              state_d = ST_TXACK;
              ptr_d   = ptr_inc;
            end else begin
              oe_d     = ~txsh_q[6];
              txsh_d   = {txsh_q[5:0], 1'b0};
              bitcnt_d = bitcnt_q + 3'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) state_d = sda_s ? ST_WAIT : ST_TXLOAD;
        end
        ST_TXLOAD: begin
          if (scl_fall) begin
            state_d  = ST_TX;
            txsh_d   = rd_data[6:0];
            oe_d     = ~rd_data[7];
            bitcnt_d = '0;
          end
        end
        default: oe_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= RX_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txsh_q   <= '0;
      done_q   <= 1'b0;
      ackok_q  <= 1'b0;
      rw_q     <= 1'b0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      txsh_q   <= txsh_d;
      done_q   <= done_d;
      ackok_q  <= ackok_d;
      rw_q     <= rw_d;
      ptr_q    <= ptr_d;
      oe_q     <= oe_d;
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_addr = ptr_q;
  assign wr_data = rx_byte;
  assign rd_addr = ptr_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe); // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK) |-> sda_oe); // R3
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !sda_oe); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX && scl_fall && bitcnt_q == 3'd7 && ptr_q == AW'(DEPTH-1)
     && !start_det && !stop_det) |=> (ptr_q == '0)); // R8
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_oe)); // R10
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_RX && kind_q == RX_DEV && bitcnt_q == 3'd0)); // R11

endmodule

// File: rtl/cfg_eeprom_slave.sv
module cfg_eeprom_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         DEPTH    = 16,
  parameter int         SYNC_STG = 2,
  localparam int        AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic [1:0]    rst_pipe_q;
  logic          rst_core_n;
  logic [1:0]    bus_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  tw_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({scl_i, sda_i}),
    .q     (bus_s)
  );

  tw_ctrl #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .scl_s   (bus_s[1]),
    .sda_s   (bus_s[0]),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr)
  );

  tw_regfile #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/cfg_eeprom_slave_bench.sv
module cfg_eeprom_slave_bench;

  localparam int Q = 8;
  localparam int H = 2;

  logic clk, rst_n, scl_m, sda_m;
  logic sda_oe, sda_line;
  int   n_run, n_fail;
  bit   done;

  assign sda_line = sda_m & ~sda_oe;

  cfg_eeprom_slave u_cfg_eeprom_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      scl_m = 1'b0; wclk(H);
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q/2);
    ack = ~sda_line; wclk(Q/2);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q);
      scl_m = 1'b1; wclk(Q/2);
      b[i] = sda_line; wclk(Q/2);
      scl_m = 1'b0; wclk(H);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    scl_m = 1'b0; wclk(H);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
  endtask

  task automatic t_no_start();
    bit ack;
    scl_m = 1'b0; wclk(Q);
    send_byte(8'hA0, ack);
    check(ack == 1'b0, "R2 byte before any start", ack, 0);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    bit ack;
    bus_start();
    send_byte(8'hA2, ack);
    check(ack == 1'b0, "R3 foreign address", ack, 0);
    send_byte(8'h00, ack);
    check(ack == 1'b0, "R3 silent after foreign address", ack, 0);
    bus_stop();
  endtask

  task automatic t_write();
    bit ack;
    bus_start();
    send_byte(8'hA0, ack);
    check(ack == 1'b1, "R3 own address write", ack, 1);
    send_byte(8'h03, ack);
    check(ack == 1'b1, "R4 word address ack", ack, 1);
    send_byte(8'h11, ack);
    check(ack == 1'b1, "R4 data ack 0", ack, 1);
    send_byte(8'h22, ack);
    check(ack == 1'b1, "R4 data ack 1", ack, 1);
    send_byte(8'h3C, ack);
    check(ack == 1'b1, "R4 data ack 2", ack, 1);
    bus_stop();
  endtask

  task automatic t_after_stop();
    bit ack;
    scl_m = 1'b0; wclk(Q);
    send_byte(8'hA0, ack);
    check(ack == 1'b0, "R10 byte after stop without start", ack, 0);
    bus_stop();
  endtask

  task automatic t_read_random();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h03, ack);
    bus_start();
    send_byte(8'hA1, ack);
    check(ack == 1'b1, "R11 address ack after repeated start", ack, 1);
    recv_byte(1'b1, d);
    check(d == 8'h11, "R5 first read byte", d, 8'h11);
    recv_byte(1'b1, d);
    check(d == 8'h22, "R6 sequential byte 1", d, 8'h22);
    recv_byte(1'b0, d);
    check(d == 8'h3C, "R6 sequential byte 2", d, 8'h3C);
    recv_byte(1'b0, d);
    check(d == 8'hFF, "R7 silent after missing ack", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_wrap();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h0E, ack);
    send_byte(8'hAA, ack);
    send_byte(8'hB5, ack);
    send_byte(8'hC7, ack);
    check(ack == 1'b1, "R8 write across wrap ack", ack, 1);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h0F, ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b1, d);
    check(d == 8'hB5, "R8 last location", d, 8'hB5);
    recv_byte(1'b1, d);
    check(d == 8'hC7, "R8 wrapped to location 0", d, 8'hC7);
    recv_byte(1'b0, d);
    check(d == 8'h00, "R8 location 1 untouched", d, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h1E, ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);
    check(d == 8'hAA, "R4 word address uses low bits", d, 8'hAA);
    bus_stop();
  endtask

  task automatic t_current_read();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h04, ack);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ack);
    check(ack == 1'b1, "R11 read ack with kept pointer", ack, 1);
    recv_byte(1'b0, d);
    check(d == 8'h22, "R11 pointer kept across stop", d, 8'h22);
    bus_stop();
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wclk(4);
    check(sda_oe == 1'b0, "R1 during reset", sda_oe, 0);
    rst_n = 1'b1;
    wclk(6);
    t_reset();
    t_no_start();
    t_bad_addr();
    t_write();
    t_after_stop();
    t_read_random();
    t_wrap();
    t_current_read();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule